// File: doc/BRIEF.md
# Stream Reuse Learner

This block sits beside one bank of a shared graphics last-level cache. It estimates how likely blocks from each traffic stream are to be used again, and it learns this from a small group of sampled sets. The cache reports every fill and every hit by giving the stream that caused it, the epoch state stored with the line and the set index. The block marks sets whose low index bits match a fixed pattern as sampled. The cache uses plain SRRIP in those sets, and only events that land in them train the estimates.

Eight saturating counters record the training events: depth fills and depth hits, texture fills and hits split by epoch, render-target production, and render-target consumption by the texture stream. Every few sampled events, all counters are halved, so that older behaviour fades out. Comparators with shifted inputs turn the counters into four class codes. The cache reads these codes when it picks insertion and promotion priorities in all the sets that are not sampled. The class codes depend only on the counter registers, so the class that follows an event is visible in the cycle after that event.

Top module: `stream_reuse_learner`

## Requirements
- R1: After reset, all counters and the aging interval are zero, and all four class outputs read high (code 2).
- R2: A set is sampled when set index bits [4:0] equal 5'b00000. `sample_set` shows this combinationally. An event to a set that is not sampled changes no counter and no class.
- R3: A sampled depth event (stream code 1) adds one to the depth fill count when `evt_hit` is 0, and one to the depth hit count when `evt_hit` is 1.
- R4: A sampled texture fill (stream code 2, `evt_hit`=0) adds one to the epoch-0 fill count. A sampled texture hit on a line whose epoch code is 3 (produced by the render-target stream) adds one to the epoch-0 fill count and one to the consumption count.
- R5: A sampled texture hit with epoch code 0 adds one to both the epoch-0 hit count and the epoch-1 fill count. With epoch code 1 it adds one to the epoch-1 hit count. With epoch code 2 it changes nothing.
- R6: A sampled render-target fill (stream code 3) adds one to the production count. Render-target hits (blending) and events of stream code 0 change no counter.
- R7: Each of the depth, texture-epoch-0 and texture-epoch-1 classes is low (code 0) when its fill count is greater than 8 times its hit count. Otherwise the class is high (code 2).
- R8: The render-target class is low (code 0) when production is greater than 16 times consumption. It is medium (code 1) when production is greater than 8 times consumption but at most 16 times. Otherwise it is high (code 2).
- R9: Every valid event to a sampled set advances a 7-bit interval count. The event that moves this count from 127 to 0 halves all eight counters (rounding down) on that same edge.
- R10: When the halving edge also carries an increment, the counter is halved first and the increment is added to the halved value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A cache fill or hit is reported this cycle |
| evt_hit | input | 1 | 1 = hit, 0 = fill |
| evt_stream | input | 2 | 0 other, 1 depth, 2 texture, 3 render target |
| evt_epoch | input | 2 | Line state: 0 epoch 0, 1 epoch 1, 2 epoch 2 or later, 3 render-target produced |
| set_idx | input | 10 | Set index of the access |
| sample_set | output | 1 | The set index selects a sampled set |
| z_class | output | 2 | Depth reuse class |
| tex_e0_class | output | 2 | Texture epoch-0 reuse class |
| tex_e1_class | output | 2 | Texture epoch-1 reuse class |
| rt_class | output | 2 | Render-to-texture reuse class |

## Verification
Any counter that misses an increment or takes an extra one moves a class comparison across its 8x or 16x boundary. The stimulus therefore pushes each count right up to that boundary, and the wrong class shows up in the cycle after the event that should have moved it. Faults in the halving logic stay hidden until the 128th sampled event. After that event, class values that disagree with the halved counts appear within a few events, and the bench checks this for both the pure halving case and the halving-with-increment case. An event to a set that is not sampled, or a stream and epoch combination that should do nothing, is shown to be ignored when the next check finds the classes unchanged.

// File: rtl/srl_pkg.sv
package srl_pkg;

    // number of learning counters and their slots; each fill count sits
    // directly below its matching hit count so pairs can be indexed as 2b, 2b+1
    localparam int NUM_CNT  = 8;
    localparam int NUM_BIN  = 3;
    localparam int C_FILL_Z  = 0;
    localparam int C_HIT_Z   = 1;
    localparam int C_FILL_E0 = 2;
    localparam int C_HIT_E0  = 3;
    localparam int C_FILL_E1 = 4;
    localparam int C_HIT_E1  = 5;
    localparam int C_PROD    = 6;
    localparam int C_CONS    = 7;

    typedef enum logic [1:0] {
        STR_OTHER = 2'd0,
        STR_DEPTH = 2'd1,
        STR_TEX   = 2'd2,
        STR_RT    = 2'd3
    } stream_e;

    typedef enum logic [1:0] {
        EP_E0    = 2'd0,
        EP_E1    = 2'd1,
        EP_E2P   = 2'd2,
        EP_RTOWN = 2'd3
    } epoch_e;

    typedef enum logic [1:0] {
        REUSE_LOW  = 2'd0,
        REUSE_MED  = 2'd1,
        REUSE_HIGH = 2'd2
    } reuse_e;

endpackage

// File: rtl/srl_event_decode.sv
module srl_event_decode
    import srl_pkg::*;
#(
    parameter int SET_W        = 10,
    parameter int SAMP_BITS    = 5,
    parameter int SAMP_PATTERN = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic               evt_hit,
    input  logic [1:0]         evt_stream,
    input  logic [1:0]         evt_epoch,
    input  logic [SET_W-1:0]   set_idx,
    output logic               samp,
    output logic               tick,
    output logic [NUM_CNT-1:0] inc
);

    localparam logic [SAMP_BITS-1:0] PAT = SAMP_BITS'(SAMP_PATTERN);

    always_comb begin
        samp = (set_idx[SAMP_BITS-1:0] == PAT);
        tick = evt_valid && samp;
        inc  = '0;
        if (tick) begin
            case (evt_stream)
                STR_DEPTH: begin
                    if (evt_hit) inc[C_HIT_Z]  = 1'b1;
                    else         inc[C_FILL_Z] = 1'b1;
                end
                STR_TEX: begin
                    if (!evt_hit) begin
                        inc[C_FILL_E0] = 1'b1;
                    end else begin
                        case (evt_epoch)
                            EP_E0: begin
                                inc[C_HIT_E0]  = 1'b1;
                                inc[C_FILL_E1] = 1'b1;
                            end
                            EP_E1:    inc[C_HIT_E1] = 1'b1;
                            EP_RTOWN: begin
                                inc[C_FILL_E0] = 1'b1;
                                inc[C_CONS]    = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                STR_RT: begin
                    if (!evt_hit) inc[C_PROD] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R4
    consume_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc[C_CONS] |-> inc[C_FILL_E0]);

    // R5
    e0_hit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc[C_HIT_E0] |-> inc[C_FILL_E1]);

    // R3
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(inc) <= 2);

endmodule

// File: rtl/srl_counter_bank.sv
module srl_counter_bank
    import srl_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int INTV_W = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic [NUM_CNT-1:0]            inc,
    output logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
    localparam logic [INTV_W-1:0] INTV_LAST = '1;

    typedef struct packed {
        logic [INTV_W-1:0]            intv;
        logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    } bank_t;

    bank_t st_d, st_q;
    logic  halve;
    logic [NUM_CNT-1:0][CNT_W-1:0] base_v;

    always_comb begin
        st_d  = st_q;
        halve = tick && (st_q.intv == INTV_LAST);
        if (tick) st_d.intv = st_q.intv + 1'b1;
        for (int i = 0; i < NUM_CNT; i++) begin
            base_v[i] = halve ? (st_q.cnt[i] >> 1) : st_q.cnt[i];
            if (inc[i] && (base_v[i] != CNT_MAX)) st_d.cnt[i] = base_v[i] + 1'b1;
            else                                  st_d.cnt[i] = base_v[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        // R9
        halve_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            halve |=> (32'(cnt[g]) <= 32'($past(cnt[g]) >> 1) + 32'd1));
        // R2
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> $stable(cnt[g]));
        // R3
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] == CNT_MAX && !halve) |=> cnt[g] == CNT_MAX);
    end

endmodule

// File: rtl/srl_hint_calc.sv
module srl_hint_calc
    import srl_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int T_SHIFT      = 3,
    parameter int RT_LO_SHIFT  = 4,
    parameter int RT_MED_SHIFT = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
    output logic [NUM_BIN-1:0][1:0]       bin_class,
    output logic [1:0]                    rt_class
);

    localparam int MAX_SH = (T_SHIFT > RT_LO_SHIFT) ? T_SHIFT : RT_LO_SHIFT;
    localparam int WIDE_W = CNT_W + MAX_SH + 1;

    for (genvar b = 0; b < NUM_BIN; b++) begin : g_bin
        logic [WIDE_W-1:0] fill_w, hit_w;
        assign fill_w = WIDE_W'(cnt[2*b]);
        assign hit_w  = WIDE_W'(cnt[2*b+1]) << T_SHIFT;
        assign bin_class[b] = (fill_w > hit_w) ? REUSE_LOW : REUSE_HIGH;

        // R7
        bin_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bin_class[b] != REUSE_MED && bin_class[b] != 2'd3);
    end

    logic [WIDE_W-1:0] prod_w, cons_lo_w, cons_med_w;

    always_comb begin
        prod_w     = WIDE_W'(cnt[C_PROD]);
        cons_lo_w  = WIDE_W'(cnt[C_CONS]) << RT_LO_SHIFT;
        cons_med_w = WIDE_W'(cnt[C_CONS]) << RT_MED_SHIFT;
        if (prod_w > cons_lo_w)       rt_class = REUSE_LOW;
        else if (prod_w > cons_med_w) rt_class = REUSE_MED;
        else                          rt_class = REUSE_HIGH;
    end

    // R8
    rt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_class != 2'd3);

    // R8
    rt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[C_PROD] == '0) |-> rt_class == REUSE_HIGH);

endmodule

// File: rtl/stream_reuse_learner.sv
module stream_reuse_learner
    import srl_pkg::*;
#(
    parameter int SET_W        = 10,
    parameter int SAMP_BITS    = 5,
    parameter int SAMP_PATTERN = 0,
    parameter int CNT_W        = 8,
    parameter int INTV_W       = 7,
    parameter int T_SHIFT      = 3,
    parameter int RT_LO_SHIFT  = 4,
    parameter int RT_MED_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic             evt_hit,
    input  logic [1:0]       evt_stream,
    input  logic [1:0]       evt_epoch,
    input  logic [SET_W-1:0] set_idx,
    output logic             sample_set,
    output logic [1:0]       z_class,
    output logic [1:0]       tex_e0_class,
    output logic [1:0]       tex_e1_class,
    output logic [1:0]       rt_class
);

    logic                          tick;
    logic [NUM_CNT-1:0]            inc;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic [NUM_BIN-1:0][1:0]       bin_class;

    srl_event_decode #(
        .SET_W(SET_W), .SAMP_BITS(SAMP_BITS), .SAMP_PATTERN(SAMP_PATTERN)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_hit(evt_hit),
        .evt_stream(evt_stream), .evt_epoch(evt_epoch), .set_idx(set_idx),
        .samp(sample_set), .tick(tick), .inc(inc)
    );

    srl_counter_bank #(.CNT_W(CNT_W), .INTV_W(INTV_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .tick(tick), .inc(inc), .cnt(cnt)
    );

    srl_hint_calc #(
        .CNT_W(CNT_W), .T_SHIFT(T_SHIFT),
        .RT_LO_SHIFT(RT_LO_SHIFT), .RT_MED_SHIFT(RT_MED_SHIFT)
    ) u_hint (
        .clk(clk), .rst_n(rst_n), .cnt(cnt),
        .bin_class(bin_class), .rt_class(rt_class)
    );

    assign z_class      = bin_class[0];
    assign tex_e0_class = bin_class[1];
    assign tex_e1_class = bin_class[2];

    // R6
    rt_blend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_stream == STR_RT && evt_hit) |=> $stable(cnt[C_PROD]) || $past(cnt[C_PROD] != '0));

    // R1
    reset_class_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (z_class == REUSE_HIGH && rt_class == REUSE_HIGH));

endmodule

// File: tb/sim_stream_reuse_learner.sv
module sim_stream_reuse_learner;

    localparam logic [1:0] LO = 2'd0, MD = 2'd1, HI = 2'd2;
    localparam int NROWS = 14;

    typedef struct packed {
        logic       hit;
        logic [1:0] stream;
        logic [1:0] epoch;
        logic       samp;
        logic [7:0] reps;
        logic [3:0] req;
        logic [1:0] ez, e0, e1, ert;
    } row_t;

    // stimulus rows and expected classes after each burst
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 2'd1, 2'd0, 1'b1, 8'd9,  4'd3, LO, HI, HI, HI}, // R3 R7 depth fills 9/0
        '{1'b1, 2'd1, 2'd0, 1'b1, 8'd1,  4'd7, LO, HI, HI, HI}, // R7 9 > 8*1
        '{1'b1, 2'd1, 2'd0, 1'b1, 8'd1,  4'd7, HI, HI, HI, HI}, // R7 9 <= 8*2
        '{1'b0, 2'd1, 2'd0, 1'b0, 8'd20, 4'd2, HI, HI, HI, HI}, // R2 unsampled ignored
        '{1'b0, 2'd3, 2'd0, 1'b1, 8'd1,  4'd8, HI, HI, HI, LO}, // R6 R8 prod 1 cons 0
        '{1'b1, 2'd2, 2'd3, 1'b1, 8'd1,  4'd4, HI, LO, HI, HI}, // R4 consume
        '{1'b0, 2'd3, 2'd0, 1'b1, 8'd8,  4'd8, HI, LO, HI, MD}, // R8 prod 9
        '{1'b0, 2'd3, 2'd0, 1'b1, 8'd8,  4'd8, HI, LO, HI, LO}, // R8 prod 17
        '{1'b1, 2'd3, 2'd0, 1'b1, 8'd5,  4'd6, HI, LO, HI, LO}, // R6 blending ignored
        '{1'b1, 2'd2, 2'd0, 1'b1, 8'd1,  4'd5, HI, HI, LO, LO}, // R5 hit in E0
        '{1'b1, 2'd2, 2'd1, 1'b1, 8'd1,  4'd5, HI, HI, HI, LO}, // R5 hit in E1
        '{1'b0, 2'd2, 2'd0, 1'b1, 8'd8,  4'd4, HI, LO, HI, LO}, // R4 fill_e0 9 > 8
        '{1'b1, 2'd2, 2'd2, 1'b1, 8'd3,  4'd5, HI, LO, HI, LO}, // R5 E2 ignored
        '{1'b0, 2'd0, 2'd0, 1'b1, 8'd3,  4'd6, HI, LO, HI, LO}  // R6 other stream ignored
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0;
    logic       evt_hit = 1'b0;
    logic [1:0] evt_stream = 2'd0;
    logic [1:0] evt_epoch = 2'd0;
    logic [9:0] set_idx = 10'd0;
    logic       sample_set;
    logic [1:0] z_class, tex_e0_class, tex_e1_class, rt_class;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stream_reuse_learner u0 (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_hit(evt_hit),
        .evt_stream(evt_stream), .evt_epoch(evt_epoch), .set_idx(set_idx),
        .sample_set(sample_set), .z_class(z_class), .tex_e0_class(tex_e0_class),
        .tex_e1_class(tex_e1_class), .rt_class(rt_class)
    );

    task automatic check(input int req, input string what, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int req, input logic [1:0] ez, input logic [1:0] e0,
                             input logic [1:0] e1, input logic [1:0] ert);
        check(req, "z_class", z_class, ez);
        check(req, "tex_e0_class", tex_e0_class, e0);
        check(req, "tex_e1_class", tex_e1_class, e1);
        check(req, "rt_class", rt_class, ert);
    endtask

    task automatic burst(input logic hit, input logic [1:0] stream, input logic [1:0] epoch,
                         input logic samp, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            evt_valid  = 1'b1;
            evt_hit    = hit;
            evt_stream = stream;
            evt_epoch  = epoch;
            set_idx    = samp ? 10'h3E0 : 10'h3E1;
        end
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all(1, HI, HI, HI, HI);
        rst_n = 1'b1;

        // table walk, 50 sampled events in total
        for (int r = 0; r < NROWS; r++) begin
            burst(ROWS[r].hit, ROWS[r].stream, ROWS[r].epoch, ROWS[r].samp, int'(ROWS[r].reps));
            // R2 sample flag from set index
            check(2, "sample_set", {1'b0, sample_set}, {1'b0, ROWS[r].samp});
            check_all(int'(ROWS[r].req), ROWS[r].ez, ROWS[r].e0, ROWS[r].e1, ROWS[r].ert);
        end

        // R9 advance interval to 127 with no counter change
        burst(1'b0, 2'd0, 2'd0, 1'b1, 77);
        check_all(9, HI, LO, HI, LO);
        // R9 128th event halves everything: z 4/1 e0 4/0 e1 0/0 rt 8/0
        burst(1'b1, 2'd3, 2'd0, 1'b1, 1);
        check_all(9, HI, LO, HI, LO);
        // R9 six depth fills: 10 > 8*1 (unhalved would be 15 vs 16)
        burst(1'b0, 2'd1, 2'd0, 1'b1, 6);
        check(9, "z_class after halving", z_class, LO);
        // R9 consume: prod 8 cons 1 (unhalved 17/2 -> medium)
        burst(1'b1, 2'd2, 2'd3, 1'b1, 1);
        check(9, "rt_class after halving", rt_class, HI);

        // R10 reach 127 again, then a depth fill as the wrapping event
        burst(1'b0, 2'd0, 2'd0, 1'b1, 120);
        burst(1'b0, 2'd1, 2'd0, 1'b1, 1);
        check(10, "z_class at wrap", z_class, LO);
        check(10, "rt_class at wrap", rt_class, LO);
        burst(1'b1, 2'd1, 2'd0, 1'b1, 1);
        check(10, "z_class fill 6 hit 1", z_class, HI);
        burst(1'b0, 2'd1, 2'd0, 1'b1, 3);
        check(10, "z_class halve-then-add", z_class, LO);

        // R1 reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_all(1, HI, HI, HI, HI);
        // R3 after reset a single depth fill outweighs zero hits
        burst(1'b0, 2'd1, 2'd0, 1'b1, 1);
        check(3, "z_class after reset", z_class, LO);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule